// File: doc/BRIEF.md
# H4 Transport Packet Deframer

This block sits behind a UART receiver and turns its byte stream into whole H4 transport packets. The first byte of every packet is an indicator that names the packet type. The block uses it, together with the length fields in the header, to work out how long each packet is. Each byte is written into a local packet store at its offset from the indicator. When the last byte arrives, the block offers a descriptor that carries the type and the total length in bytes. The consumer can then read the stored bytes through a plain read port before it takes the descriptor.

Length discovery runs in three phases. The lead phase collects the indicator and the byte that follows it. The header phase extends the packet to its full header length. The payload phase extends it by the payload length taken from that header. Packets with an unknown indicator, event packets arriving from the host side, and packets longer than the store are all reported on an error strobe with a code, and they never produce a descriptor. Apart from an unknown indicator, each of these cases is consumed over its full length, so the parser stays aligned with the stream.

Both stream edges use valid/ready. The byte input is accepted on any cycle where `in_valid` and `in_ready` are both high. While a descriptor is waiting (`pkt_valid` high and `pkt_ready` low), `in_ready` is low, so the byte source stalls until the consumer takes the descriptor. The descriptor holds its type and length unchanged until it is taken. The `enable` input and the error strobe are plain signals.

Top module: `h4_deframer`

## Requirements
- R1: The accepted indicator values are 1 (command), 2 (ACL), 3 (SCO), 4 (event), 6 (negotiation) and 7 (keep-alive). A packet that is delivered reports its indicator on `pkt_type`. Any other value in the first byte is dropped, raises `err_valid` with `err_code` = 1 in the next cycle, and leaves the parser waiting for an indicator.
- R2: The full header length, counting the indicator, is 4 for command, 3 for event, 5 for ACL and 4 for SCO. It is byte 1 plus 2 for negotiation and 4 for keep-alive. Negotiation and keep-alive packets have no payload.
- R3: The payload length is byte 3 for command, byte 2 for event, byte 3 plus 256 times byte 4 for ACL, and byte 3 for SCO, where byte 0 is the indicator. `pkt_len` equals the header length plus the payload length.
- R4: When a command has byte 1 = 0x00 and byte 2 = 0xFC (opcode 0xFC00), its payload length is byte 3 rounded up to the next even number. Any other opcode uses byte 3 unchanged.
- R5: `pkt_valid` rises in the cycle after the last byte of a packet is accepted. It stays high with `pkt_type` and `pkt_len` stable until a cycle in which `pkt_ready` is high. While `pkt_valid` is high and `enable` is high, `in_ready` is low.
- R6: While a descriptor is offered, `rd_data` shows the stored byte at offset `rd_addr` one cycle after `rd_addr` is applied. Offset 0 holds the indicator.
- R7: A packet with indicator 4 is consumed over its full length. One cycle after its last byte, it raises `err_valid` with `err_code` = 2 and never raises `pkt_valid`.
- R8: A packet whose total length exceeds `MAX_LEN` is consumed over its full length. One cycle after its last byte, it raises `err_valid` with `err_code` = 3 and never raises `pkt_valid`. The packet that follows it parses normally.
- R9: While `enable` is low, `in_ready` is high and every offered byte is discarded. The parse position is kept, so a packet that was interrupted resumes and completes correctly once `enable` returns high.
- R10: After reset, `pkt_valid` and `err_valid` are low, `in_ready` is high and the parser waits for an indicator.
- R11: In the cycle after a descriptor is taken, `pkt_valid` is low and `in_ready` is high, so the next indicator byte can be accepted straight away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; bytes are discarded while low |
| in_valid | input | 1 | Byte offered by the UART side |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_data | input | 8 | Received byte |
| pkt_valid | output | 1 | Packet descriptor offered |
| pkt_ready | input | 1 | Consumer takes the descriptor |
| pkt_type | output | 8 | Indicator of the delivered packet |
| pkt_len | output | 17 | Total length in bytes, indicator included |
| rd_addr | input | $clog2(MAX_LEN) | Byte offset to read from the packet store |
| rd_data | output | 8 | Stored byte, one cycle after `rd_addr` |
| err_valid | output | 1 | One-cycle error strobe |
| err_code | output | 2 | 1 unknown indicator, 2 host-side event, 3 oversize |

## Verification
For each packet type, the bench sweeps the length field across a range. This separates header sizing from payload sizing, because a wrong header size moves every length in a sweep while a wrong payload field scales with it. The command sweep is run twice with the same lengths: once with an ordinary opcode, and once with the vendor opcode and its neighbour 0xFC01. This isolates the rounding to the single opcode that needs it. All 256 values of the first byte are offered, to separate accepted indicators from rejected ones. Oversize ACL packets with the length in the low byte and in the high byte check the 16-bit field order, and the packet sent after each one shows that alignment is kept. A packet interrupted by a disabled stretch of junk bytes shows that those bytes are discarded and not parsed.

// File: rtl/h4_pkg.sv
package h4_pkg;

  // Largest possible packet: indicator + 4 header bytes + 16-bit payload.
  localparam int LEN_W = 17;

  localparam logic [7:0] IND_CMD   = 8'd1;
  localparam logic [7:0] IND_ACL   = 8'd2;
  localparam logic [7:0] IND_SCO   = 8'd3;
  localparam logic [7:0] IND_EVT   = 8'd4;
  localparam logic [7:0] IND_NEG   = 8'd6;
  localparam logic [7:0] IND_ALIVE = 8'd7;

  localparam logic [15:0] VENDOR_OPC = 16'hFC00;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_UNKNOWN  = 2'd1;
  localparam logic [1:0] ERR_HOSTEVT  = 2'd2;
  localparam logic [1:0] ERR_OVERSIZE = 2'd3;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_HDR,
    PH_PAY,
    PH_HOLD
  } h4_phase_e;

endpackage

// File: rtl/h4_len_calc.sv
module h4_len_calc
  import h4_pkg::*;
(
  input  logic [7:0]       ind_i,
  input  logic [7:0]       b1_i,
  input  logic [7:0]       b2_i,
  input  logic [7:0]       b3_i,
  input  logic [7:0]       b4_i,
  output logic             known_o,
  output logic [LEN_W-1:0] hdr_o,
  output logic [LEN_W-1:0] pay_o
);

  logic [LEN_W-1:0] b1_w, b2_w, b3_w, b4_w;
  logic             vendor;

  assign b1_w   = LEN_W'(b1_i);
  assign b2_w   = LEN_W'(b2_i);
  assign b3_w   = LEN_W'(b3_i);
  assign b4_w   = LEN_W'(b4_i);
  assign vendor = ({b2_i, b1_i} == VENDOR_OPC);

  always_comb begin
    known_o = 1'b1;
    hdr_o   = '0;
    pay_o   = '0;
    case (ind_i)
      IND_CMD: begin
        hdr_o = LEN_W'(4);
        pay_o = vendor ? (b3_w + LEN_W'(b3_i[0])) : b3_w;
      end
      IND_ACL: begin
        hdr_o = LEN_W'(5);
        pay_o = b3_w | (b4_w << 8);
      end
      IND_SCO: begin
        hdr_o = LEN_W'(4);
        pay_o = b3_w;
      end
      IND_EVT: begin
        hdr_o = LEN_W'(3);
        pay_o = b2_w;
      end
      IND_NEG: begin
        hdr_o = b1_w + LEN_W'(2);
      end
      IND_ALIVE: begin
        hdr_o = LEN_W'(4);
      end
      default: known_o = 1'b0;
    endcase
  end

  always_comb begin
    if (ind_i == IND_CMD && b2_i == 8'hFC && b1_i == 8'h00) begin
      AST_VENDOR_EVEN: assert (pay_o[0] == 1'b0); // R4
    end
  end

endmodule

// File: rtl/h4_pkt_buf.sv
module h4_pkt_buf #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/h4_frame_fsm.sv
module h4_frame_fsm
  import h4_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  localparam int AW = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [7:0]       pkt_type,
  output logic [LEN_W-1:0] pkt_len,
  output logic             err_valid,
  output logic [1:0]       err_code,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic [7:0]       view_ind,
  output logic [7:0]       view_b1,
  output logic [7:0]       view_b2,
  output logic [7:0]       view_b3,
  output logic [7:0]       view_b4,
  input  logic             calc_known,
  input  logic [LEN_W-1:0] calc_hdr,
  input  logic [LEN_W-1:0] calc_pay
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam int HB = 4;

  h4_phase_e        ph_q;
  logic [LEN_W-1:0] cnt_q, need_q, nxt, sum, fin_len;
  logic [7:0]       ind_q;
  logic [7:0]       hb_q [HB];
  logic [7:0]       hv   [HB];
  logic             acc, at_lead0, hdr_done, fin;

  assign in_ready  = !enable || (ph_q != PH_HOLD);
  assign acc       = in_valid && in_ready && enable;
  assign pkt_valid = (ph_q == PH_HOLD);
  assign nxt       = cnt_q + LEN_W'(1);
  assign at_lead0  = (ph_q == PH_LEAD) && (cnt_q == '0);

  // Header view: stored header bytes with the arriving byte merged in place,
  // so lengths are known in the same cycle as the byte that completes them.
  for (genvar k = 0; k < HB; k++) begin : g_view
    assign hv[k] = (acc && cnt_q == LEN_W'(k + 1)) ? in_data : hb_q[k];
  end

  assign view_ind = at_lead0 ? in_data : ind_q;
  assign view_b1  = hv[0];
  assign view_b2  = hv[1];
  assign view_b3  = hv[2];
  assign view_b4  = hv[3];

  assign sum      = calc_hdr + calc_pay;
  assign hdr_done = ((ph_q == PH_LEAD && cnt_q == LEN_W'(1)) || ph_q == PH_HDR)
                    && (nxt == calc_hdr);
  assign fin      = acc && ((hdr_done && sum == nxt) ||
                            (ph_q == PH_PAY && nxt == need_q));
  assign fin_len  = (ph_q == PH_PAY) ? need_q : sum;

  assign wr_en   = acc && (cnt_q < MAX_L) && (ph_q != PH_HOLD);
  assign wr_addr = cnt_q[AW-1:0];
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_LEAD;
      cnt_q     <= '0;
      need_q    <= '0;
      ind_q     <= '0;
      pkt_type  <= '0;
      pkt_len   <= '0;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
      for (int k = 0; k < HB; k++) hb_q[k] <= '0;
    end else begin
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
      if (ph_q == PH_HOLD) begin
        if (pkt_ready) ph_q <= PH_LEAD;
      end else if (acc) begin
        if (at_lead0) begin
          if (!calc_known) begin
            err_valid <= 1'b1;
            err_code  <= ERR_UNKNOWN;
          end else begin
            ind_q <= in_data;
            cnt_q <= LEN_W'(1);
          end
        end else begin
          cnt_q <= nxt;
          for (int k = 0; k < HB; k++)
            if (cnt_q == LEN_W'(k + 1)) hb_q[k] <= in_data;
          if (fin) begin
            cnt_q <= '0;
            if (ind_q == IND_EVT) begin
              ph_q      <= PH_LEAD;
              err_valid <= 1'b1;
              err_code  <= ERR_HOSTEVT;
            end else if (fin_len > MAX_L) begin
              ph_q      <= PH_LEAD;
              err_valid <= 1'b1;
              err_code  <= ERR_OVERSIZE;
            end else begin
              ph_q     <= PH_HOLD;
              pkt_len  <= fin_len;
              pkt_type <= ind_q;
            end
          end else if (hdr_done) begin
            ph_q   <= PH_PAY;
            need_q <= sum;
          end else if (ph_q == PH_LEAD) begin
            ph_q <= PH_HDR;
          end
        end
      end
    end
  end

  AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_len) && $stable(pkt_type)); // R5
  AST_STALL_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && enable |-> !in_ready); // R5
  AST_NO_HOST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_type != IND_EVT); // R7
  AST_LEN_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len <= MAX_L) && (pkt_len >= LEN_W'(2))); // R8
  AST_ERR_NOT_WITH_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_valid && pkt_valid)); // R7
  AST_DISABLED_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && ph_q != PH_HOLD |=> $stable(cnt_q) && $stable(ph_q)); // R9

endmodule

// File: rtl/h4_deframer.sv
module h4_deframer
  import h4_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  localparam int AW = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [7:0]       pkt_type,
  output logic [LEN_W-1:0] pkt_len,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             err_valid,
  output logic [1:0]       err_code
);

  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic [7:0]       v_ind, v_b1, v_b2, v_b3, v_b4;
  logic             c_known;
  logic [LEN_W-1:0] c_hdr, c_pay;

  h4_frame_fsm #(.MAX_LEN(MAX_LEN)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_type   (pkt_type),
    .pkt_len    (pkt_len),
    .err_valid  (err_valid),
    .err_code   (err_code),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .view_ind   (v_ind),
    .view_b1    (v_b1),
    .view_b2    (v_b2),
    .view_b3    (v_b3),
    .view_b4    (v_b4),
    .calc_known (c_known),
    .calc_hdr   (c_hdr),
    .calc_pay   (c_pay)
  );

  h4_len_calc calc_i (
    .ind_i   (v_ind),
    .b1_i    (v_b1),
    .b2_i    (v_b2),
    .b3_i    (v_b3),
    .b4_i    (v_b4),
    .known_o (c_known),
    .hdr_o   (c_hdr),
    .pay_o   (c_pay)
  );

  h4_pkt_buf #(.DEPTH(MAX_LEN)) buf_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: tb/h4_deframer_tb.sv
module h4_deframer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 64;
  localparam int AW         = 6;
  localparam int WDOG       = 150000;

  logic          clk = 1'b0;
  logic          rst_n, enable, in_valid, pkt_ready;
  logic          in_ready, pkt_valid, err_valid;
  logic [7:0]    in_data, pkt_type, rd_data;
  logic [16:0]   pkt_len;
  logic [AW-1:0] rd_addr;
  logic [1:0]    err_code;

  int checks = 0;
  int fails  = 0;
  logic [7:0] tbb [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  h4_deframer #(.MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_type(pkt_type), .pkt_len(pkt_len),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .err_valid(err_valid), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected total length, worked out from R2/R3/R4.
  function automatic int exp_total();
    int p;
    case (tbb[0])
      8'd1: begin
        p = int'(tbb[3]);
        if (tbb[1] == 8'h00 && tbb[2] == 8'hFC) p = p + (p % 2);
        return 4 + p;
      end
      8'd2: return 5 + int'(tbb[3]) + 256 * int'(tbb[4]);
      8'd3: return 4 + int'(tbb[3]);
      8'd4: return 3 + int'(tbb[2]);
      8'd6: return 2 + int'(tbb[1]);
      8'd7: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic build(input int t, input int b1, input int b2, input int b3,
                       input int b4, input int seed);
    tbb[0] = 8'(t); tbb[1] = 8'(b1); tbb[2] = 8'(b2);
    tbb[3] = 8'(b3); tbb[4] = 8'(b4);
    for (int i = 5; i < 512; i++) tbb[i] = 8'(i * 13 + seed);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_range(input int lo, input int hi);
    for (int i = lo; i < hi; i++) send_byte(tbb[i]);
  endtask

  task automatic check_result(input string tag);
    int n;
    int mism;
    n = exp_total();
    @(negedge clk);
    if (tbb[0] == 8'd4) begin
      chk(err_valid && err_code == 2'd2, "R7", {err_valid, err_code}, 6);
      chk(!pkt_valid, "R7", pkt_valid, 0);
    end else if (n > MAXL) begin
      chk(err_valid && err_code == 2'd3, "R8", {err_valid, err_code}, 7);
      chk(!pkt_valid, "R8", pkt_valid, 0);
    end else begin
      chk(pkt_valid == 1'b1, "R5", pkt_valid, 1);
      chk(pkt_type == tbb[0], "R1", pkt_type, tbb[0]);
      chk(int'(pkt_len) == n, tag, pkt_len, n);
      chk(in_ready == 1'b0, "R5", in_ready, 0);
      mism = 0;
      for (int i = 0; i < n; i++) begin
        @(negedge clk) rd_addr = AW'(i);
        @(negedge clk);
        if (rd_data != tbb[i]) mism++;
      end
      chk(mism == 0 && pkt_valid, "R6", mism, 0);
      pkt_ready = 1'b1;
      @(posedge clk);
      #1 pkt_ready = 1'b0;
      @(negedge clk);
      chk(!pkt_valid && in_ready, "R11", {pkt_valid, in_ready}, 1);
    end
  endtask

  task automatic deliver(input string tag);
    send_range(0, exp_total());
    check_result(tag);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", WDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; in_valid = 1'b0; in_data = '0;
    pkt_ready = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk(!pkt_valid && !err_valid, "R10", {pkt_valid, err_valid}, 0);
    rst_n  = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    chk(in_ready && !pkt_valid && !err_valid, "R10", {in_ready, pkt_valid, err_valid}, 4);

    // R1: every possible first byte
    for (int v = 0; v < 256; v++) begin
      if (!(v inside {1, 2, 3, 4, 6, 7})) begin
        send_byte(8'(v));
        @(negedge clk);
        chk(err_valid && err_code == 2'd1 && !pkt_valid, "R1",
            {pkt_valid, err_valid, err_code}, 5);
      end
    end
    build(7, 8'h12, 8'h55, 8'h00, 0, 1);
    deliver("R2");

    // R3: command with ordinary opcode, R4: vendor opcode and its neighbour
    for (int p = 0; p < 13; p++) begin
      build(1, 8'h03, 8'h0C, p, 0, p);
      deliver("R3");
      build(1, 8'h00, 8'hFC, p, 0, p + 40);
      deliver("R4");
      build(1, 8'h01, 8'hFC, p, 0, p + 80);
      deliver("R4");
    end

    // R3: ACL length low byte sweep; R8: oversize via low and high byte
    for (int d = 0; d < 60; d++) begin
      build(2, 8'h01, 8'h20, d, 0, d);
      deliver("R3");
    end
    build(2, 8'h01, 8'h20, 60, 0, 3);
    deliver("R8");
    build(7, 8'h00, 8'h55, 8'h00, 0, 2);
    deliver("R8");
    build(2, 8'h01, 8'h20, 0, 1, 4);
    deliver("R8");
    build(3, 8'h05, 8'h00, 2, 0, 9);
    deliver("R8");

    // R3: SCO sweep
    for (int d = 0; d < 11; d++) begin
      build(3, 8'h05, 8'h00, d, 0, d + 7);
      deliver("R3");
    end

    // R2: negotiation header sweep, keep-alive
    for (int h = 0; h < 13; h++) begin
      build(6, h, 8'h00, 8'hA0, 8'h01, h + 3);
      deliver("R2");
    end
    build(7, 8'h00, 8'h55, 8'h00, 0, 11);
    deliver("R2");

    // R7: host-side events
    for (int p = 0; p < 5; p++) begin
      build(4, 8'h0E, p, 8'h01, 8'h02, p);
      deliver("R7");
    end
    build(3, 8'h05, 8'h00, 3, 0, 21);
    deliver("R7");

    // R9: disabled stretch in the middle of a command
    build(1, 8'h03, 8'h0C, 3, 0, 33);
    send_range(0, 2);
    @(negedge clk) enable = 1'b0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R9", in_ready, 1);
      send_byte(8'hFF ^ 8'(j));
      @(negedge clk);
      chk(!err_valid && !pkt_valid, "R9", {err_valid, pkt_valid}, 0);
    end
    @(negedge clk) enable = 1'b1;
    send_range(2, exp_total());
    check_result("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule